// File: doc/BRIEF.md
# Instruction Decoder with Condition Evaluator

This block takes a 16-bit instruction word and splits it into the fields that the rest of a byte-wide core needs. It works out which of the two instruction layouts is present. It reports the 4-bit opcode, the 3-bit destination register index and the operand source. The operand source is an 8-bit immediate, a 3-bit short immediate or a source register. In the layout that carries a condition, it tests that condition against the arithmetic flags (zero, carry, sign) and four external binary inputs, and it drives an execute-enable. The layout with the wide immediate always executes.

The decoding path is fully combinational. The flags are taken as they stand in the same cycle. The four external inputs are asynchronous to the core, so each one passes through a two-stage synchronizer before it can affect the result. The all-zero word is reported as a no-operation that never executes. The all-ones word is reported as the invalid/trap word, which decodes as a move of FFh into the program counter (register 7). Fetch, the register file and the ALU are outside this block.

Top module: `insn_decode_unit`

## Requirements
- R1: When bit 15 of the word is 1, the wide-immediate layout is reported: `imm_form_o`=1, `operand_sel_o`=2, `imm_o`=word[14:7], `src_idx_o`=0.
- R2: In both layouts `dest_idx_o` is word[6:4] and `opcode_o` is word[3:0]. Register index 7 is the program counter and index 0 is the first data register.
- R3: When bit 15 is 0, `src_idx_o`=word[14:12]. If word[11]=1 the operand is a short immediate: `operand_sel_o`=1 and `imm_o` is word[14:12] zero-extended. If word[11]=0 the operand is a register: `operand_sel_o`=0 and `imm_o`=0.
- R4: In the conditional layout the condition is word[10:7]. Bits 9:7 pick the test: 0 always-true, 1 zero flag, 2 carry flag, 3 sign flag, 4 to 7 external inputs 0 to 3. With word[10]=1, `exec_en_o` equals the picked test.
- R5: With word[10]=0, `exec_en_o` is the inverse of the picked test. Condition code 0000 therefore never executes.
- R6: In the wide-immediate layout `exec_en_o` is 1 whatever the flags and external inputs are.
- R7: `is_nop_o` is 1 exactly when the word is 0000h, and that word gives `exec_en_o`=0.
- R8: `is_inv_o` is 1 exactly when the word is FFFFh. That word decodes as wide-immediate with `imm_o`=FFh, `dest_idx_o`=7, `opcode_o`=Fh and `exec_en_o`=1.
- R9: A change on `ext_in_i` reaches the condition test after exactly two rising clock edges. Reset clears the synchronized copy to 0.
- R10: The flag inputs act on `exec_en_o` in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the input synchronizer |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Instruction word to decode |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_s_i | input | 1 | Sign flag |
| ext_in_i | input | 4 | Asynchronous external test inputs |
| imm_form_o | output | 1 | 1 for the wide-immediate layout |
| opcode_o | output | 4 | Operation code |
| dest_idx_o | output | 3 | Destination register index |
| src_idx_o | output | 3 | Source register index or short immediate |
| operand_sel_o | output | 2 | 0 register, 1 short immediate, 2 wide immediate |
| imm_o | output | 8 | Immediate operand value |
| exec_en_o | output | 1 | Instruction is to be carried out |
| is_nop_o | output | 1 | Word is the all-zero no-operation |
| is_inv_o | output | 1 | Word is the all-ones trap word |

## Verification
All field, operand and flag results depend only on the current word and flags, so they are due in the same cycle as the stimulus. The driver applies each stimulus after a falling edge, and the monitor samples shortly after the next rising edge. An external-input change is due two rising edges after it is applied. The driver therefore waits two cycles after each change before it queues predictions that depend on the new value. A dedicated sequence queues the old outcome for the first edge and the new outcome for the second edge, which pins the latency exactly. The reset case holds the inputs high through reset and expects the first cycle after release to still see zero.

// File: rtl/idu_pkg.sv
`timescale 1ns/1ps
// Package idu_pkg
// Shared widths and the operand-select encoding for the instruction decoder.
// Assumes a 16-bit word with two layouts selected by the top bit.
package idu_pkg;
    localparam int INSN_W    = 16;
    localparam int OPC_W     = 4;
    localparam int REG_IDX_W = 3;
    localparam int COND_W    = 4;
    localparam int IMM_W     = 8;
    localparam int NUM_EXT   = 4;

    typedef enum logic [1:0] {
        OPS_REG   = 2'd0,
        OPS_SHORT = 2'd1,
        OPS_IMM8  = 2'd2
    } opsel_e;
endpackage

// File: rtl/idu_field_split.sv
`timescale 1ns/1ps
// Module idu_field_split
// Pure wiring/decode: cuts the instruction word into its fields.
// Assumes the form bit is the MSB, followed by an 8-bit immediate (wide form)
// or source, short-immediate select and condition (conditional form),
// with destination and opcode in the low bits of both forms.
module idu_field_split
    import idu_pkg::*;
#(
    parameter int W_INSN = INSN_W,
    parameter int W_OPC  = OPC_W,
    parameter int W_REG  = REG_IDX_W,
    parameter int W_COND = COND_W,
    parameter int W_IMM  = IMM_W
) (
    input  logic [W_INSN-1:0] word_i,
    output logic              form_wide_o,
    output logic [W_OPC-1:0]  opc_o,
    output logic [W_REG-1:0]  dst_o,
    output logic [W_REG-1:0]  src_o,
    output logic              src_short_o,
    output logic [W_COND-1:0] cond_o,
    output logic [W_IMM-1:0]  imm_wide_o
);
    localparam int DST_LO   = W_OPC;
    localparam int DST_HI   = DST_LO + W_REG - 1;
    localparam int COND_LO  = DST_HI + 1;
    localparam int COND_HI  = COND_LO + W_COND - 1;
    localparam int SHSEL_B  = COND_HI + 1;
    localparam int SRC_LO   = SHSEL_B + 1;
    localparam int SRC_HI   = SRC_LO + W_REG - 1;
    localparam int IMM_LO   = DST_HI + 1;
    localparam int IMM_HI   = IMM_LO + W_IMM - 1;
    localparam int FORM_B   = W_INSN - 1;

    // Field extraction common to both forms and specific to each.
    always_comb begin
        form_wide_o = word_i[FORM_B];
        opc_o       = word_i[W_OPC-1:0];
        dst_o       = word_i[DST_HI:DST_LO];
        src_o       = word_i[SRC_HI:SRC_LO];
        src_short_o = word_i[SHSEL_B];
        cond_o      = word_i[COND_HI:COND_LO];
        imm_wide_o  = word_i[IMM_HI:IMM_LO];
    end
endmodule

// File: rtl/idu_in_sync.sv
`timescale 1ns/1ps
// Module idu_in_sync
// Two-flop synchronizer, one chain per external input bit.
// Assumes inputs are asynchronous level signals; reset clears both stages.
module idu_in_sync
    import idu_pkg::*;
#(
    parameter int N_IN = NUM_EXT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] async_i,
    output logic [N_IN-1:0] sync_o
);
    localparam int WARM_DONE = 2;

    genvar g;
    generate
        for (g = 0; g < N_IN; g++) begin : g_chain
            logic stg1_q;
            logic stg2_q;
            // Capture then re-time one external bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg1_q <= 1'b0;
                    stg2_q <= 1'b0;
                end else begin
                    stg1_q <= async_i[g];
                    stg2_q <= stg1_q;
                end
            end
            assign sync_o[g] = stg2_q;
        end
    endgenerate

    // Counts edges since reset so the latency check only looks at valid history.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  warm_q <= 2'd0;
        else if (warm_q != 2'(WARM_DONE)) warm_q <= warm_q + 2'd1;
    end

    p_two_edge_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'(WARM_DONE)) |-> (sync_o == $past(async_i, 2)));
endmodule

// File: rtl/idu_cond_eval.sv
`timescale 1ns/1ps
// Module idu_cond_eval
// Evaluates a condition code: the low bits pick a test among always-true,
// the three flags and the synchronized external inputs; the top bit keeps
// (1) or inverts (0) the picked test. Assumes 3 + 1 + N_EXT tests fill the
// select range exactly.
module idu_cond_eval
    import idu_pkg::*;
#(
    parameter int W_COND = COND_W,
    parameter int N_EXT  = NUM_EXT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W_COND-1:0] cond_i,
    input  logic              z_i,
    input  logic              c_i,
    input  logic              s_i,
    input  logic [N_EXT-1:0]  ext_i,
    output logic              pass_o
);
    localparam int SEL_W   = W_COND - 1;
    localparam int N_TESTS = 1 << SEL_W;
    localparam int EXT_LO  = 4;

    logic [N_TESTS-1:0] tests;
    logic               picked;

    // Fixed tests in the low slots of the test vector.
    always_comb begin
        tests[0] = 1'b1;
        tests[1] = z_i;
        tests[2] = c_i;
        tests[3] = s_i;
    end

    genvar g;
    generate
        for (g = 0; g < N_EXT; g++) begin : g_ext_slot
            assign tests[EXT_LO+g] = ext_i[g];
        end
    endgenerate

    // Select the test and apply the sense bit.
    always_comb begin
        picked = tests[cond_i[SEL_W-1:0]];
        pass_o = cond_i[W_COND-1] ? picked : ~picked;
    end

    p_code_zero_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == '0) |-> !pass_o);
    p_always_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_i == {1'b1, {SEL_W{1'b0}}}) |-> pass_o);
endmodule

// File: rtl/insn_decode_unit.sv
`timescale 1ns/1ps
// Module insn_decode_unit
// Top of the instruction decoder: field split, condition evaluation with
// synchronized external inputs, operand selection, and detection of the
// reserved all-zero (no-op) and all-ones (trap) words.
// Assumes flags are already registered by the ALU and stable per cycle.
module insn_decode_unit
    import idu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [INSN_W-1:0]    instr_i,
    input  logic                 flag_z_i,
    input  logic                 flag_c_i,
    input  logic                 flag_s_i,
    input  logic [NUM_EXT-1:0]   ext_in_i,
    output logic                 imm_form_o,
    output logic [OPC_W-1:0]     opcode_o,
    output logic [REG_IDX_W-1:0] dest_idx_o,
    output logic [REG_IDX_W-1:0] src_idx_o,
    output logic [1:0]           operand_sel_o,
    output logic [IMM_W-1:0]     imm_o,
    output logic                 exec_en_o,
    output logic                 is_nop_o,
    output logic                 is_inv_o
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = '1;
    localparam int PAD_W = IMM_W - REG_IDX_W;

    logic                 wide_form;
    logic [OPC_W-1:0]     opc_f;
    logic [REG_IDX_W-1:0] dst_f;
    logic [REG_IDX_W-1:0] src_f;
    logic                 short_sel;
    logic [COND_W-1:0]    cond_f;
    logic [IMM_W-1:0]     imm_f;
    logic [NUM_EXT-1:0]   ext_sync;
    logic                 cond_pass;
    opsel_e               opsel;

    idu_field_split u_split (
        .word_i      (instr_i),
        .form_wide_o (wide_form),
        .opc_o       (opc_f),
        .dst_o       (dst_f),
        .src_o       (src_f),
        .src_short_o (short_sel),
        .cond_o      (cond_f),
        .imm_wide_o  (imm_f)
    );

    idu_in_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_in_i),
        .sync_o  (ext_sync)
    );

    idu_cond_eval u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (cond_f),
        .z_i    (flag_z_i),
        .c_i    (flag_c_i),
        .s_i    (flag_s_i),
        .ext_i  (ext_sync),
        .pass_o (cond_pass)
    );

    // Operand source and immediate value per form.
    always_comb begin
        if (wide_form) begin
            opsel     = OPS_IMM8;
            imm_o     = imm_f;
            src_idx_o = '0;
        end else if (short_sel) begin
            opsel     = OPS_SHORT;
            imm_o     = {{PAD_W{1'b0}}, src_f};
            src_idx_o = src_f;
        end else begin
            opsel     = OPS_REG;
            imm_o     = '0;
            src_idx_o = src_f;
        end
    end

    // Execute-enable, reserved-word flags and pass-through fields.
    always_comb begin
        operand_sel_o = opsel;
        imm_form_o    = wide_form;
        opcode_o      = opc_f;
        dest_idx_o    = dst_f;
        exec_en_o     = wide_form | cond_pass;
        is_nop_o      = (instr_i == '0);
        is_inv_o      = &instr_i;
    end

    p_wide_always_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        imm_form_o |-> exec_en_o);
    p_nop_never_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop_o |-> (!exec_en_o && !imm_form_o));
    p_trap_to_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_inv_o |-> (exec_en_o && dest_idx_o == PC_IDX && imm_o == '1));
    p_reserved_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_nop_o, is_inv_o}));
    p_short_imm_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (operand_sel_o == 2'd1) |-> (imm_o[IMM_W-1:REG_IDX_W] == '0 && imm_o[REG_IDX_W-1:0] == src_idx_o));
endmodule

// File: tb/insn_decode_unit_tb.sv
`timescale 1ns/1ps
module insn_decode_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0;
    logic        fz = 1'b0, fc = 1'b0, fs = 1'b0;
    logic [3:0]  ext = 4'h0;
    logic [3:0]  ext_seen = 4'h0;

    logic        imm_form, exec_en, is_nop, is_inv;
    logic [3:0]  opcode;
    logic [2:0]  dest_idx, src_idx;
    logic [1:0]  operand_sel;
    logic [7:0]  imm;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    insn_decode_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr),
        .flag_z_i(fz), .flag_c_i(fc), .flag_s_i(fs), .ext_in_i(ext),
        .imm_form_o(imm_form), .opcode_o(opcode), .dest_idx_o(dest_idx),
        .src_idx_o(src_idx), .operand_sel_o(operand_sel), .imm_o(imm),
        .exec_en_o(exec_en), .is_nop_o(is_nop), .is_inv_o(is_inv)
    );

    typedef struct {
        logic [23:0] vec;
        string       tag;
    } item_t;

    item_t sb_q[$];

    // Expected outputs from the requirements, packed as
    // {exec,nop,inv,form,opsel,imm,dest,opc,src}.
    function automatic item_t model(input logic [15:0] w, input logic z, input logic c,
                                    input logic s, input logic [3:0] b);
        item_t e;
        logic raw, ex, fm;
        logic [1:0] os;
        logic [7:0] iv;
        logic [2:0] sr, k;
        fm = w[15];
        if (fm) begin
            os = 2'd2; iv = w[14:7]; sr = 3'd0; ex = 1'b1;
        end else begin
            sr = w[14:12];
            os = w[11] ? 2'd1 : 2'd0;
            iv = w[11] ? {5'b0, w[14:12]} : 8'h00;
            k  = w[9:7] - 3'd4;
            case (w[9:7])
                3'd0: raw = 1'b1;
                3'd1: raw = z;
                3'd2: raw = c;
                3'd3: raw = s;
                default: raw = b[k[1:0]];
            endcase
            ex = w[10] ? raw : ~raw;
        end
        e.vec = {ex, (w == 16'h0), (w == 16'hFFFF), fm, os, iv, w[6:4], w[3:0], sr};
        if (w == 16'h0)        e.tag = "R7";
        else if (w == 16'hFFFF) e.tag = "R8";
        else if (fm)           e.tag = "R1/R2/R6";
        else if (w[10])        e.tag = "R3/R4/R10";
        else                   e.tag = "R3/R5/R10";
        return e;
    endfunction

    // Driver: apply one word and flags after a falling edge, queue the prediction.
    task automatic drive(input logic [15:0] w, input logic z, input logic c, input logic s);
        @(negedge clk);
        instr = w; fz = z; fc = c; fs = s;
        sb_q.push_back(model(w, z, c, s, ext_seen));
    endtask

    // Change external inputs and wait until they have crossed the synchronizer (R9).
    task automatic set_ext(input logic [3:0] v);
        @(negedge clk);
        ext = v;
        repeat (2) @(negedge clk);
        ext_seen = v;
    endtask

    // Monitor: compare each queued prediction just after the next rising edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            logic [23:0] act;
            it  = sb_q.pop_front();
            act = {exec_en, is_nop, is_inv, imm_form, operand_sel, imm, dest_idx, opcode, src_idx};
            checks++;
            if (act !== it.vec) begin
                failures++;
                $display("FAIL %s instr=%h actual=%h expected=%h", it.tag, instr, act, it.vec);
            end
        end
    end

    initial begin
        item_t e;
        // Reset state (R9): inputs high throughout reset, synchronized copy starts at 0.
        ext = 4'hF;
        repeat (4) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        instr = {1'b0, 3'd0, 1'b0, 4'b1100, 3'd1, 4'h2};
        e = model(instr, 1'b0, 1'b0, 1'b0, 4'h0); e.tag = "R9 reset";
        sb_q.push_back(e);
        @(negedge clk);
        e = model(instr, 1'b0, 1'b0, 1'b0, 4'hF); e.tag = "R9 after two edges";
        sb_q.push_back(e);
        ext_seen = 4'hF;
        set_ext(4'h0);

        // Reserved words (R7, R8) with all flags and inputs set.
        set_ext(4'hF);
        drive(16'hFFFF, 1'b0, 1'b0, 1'b0);
        drive(16'h0000, 1'b1, 1'b1, 1'b1);
        drive(16'h0000, 1'b0, 1'b0, 1'b0);
        // Wide-immediate layout (R1, R2, R6) under both flag extremes.
        drive({1'b1, 8'hA5, 3'd2, 4'h6}, 1'b0, 1'b0, 1'b0);
        drive({1'b1, 8'h00, 3'd0, 4'h0}, 1'b1, 1'b1, 1'b1);
        drive({1'b1, 8'h7F, 3'd7, 4'hF}, 1'b0, 1'b1, 1'b0);
        // Conditional layout, register and short-immediate operands (R3).
        drive({1'b0, 3'd5, 1'b0, 4'b1000, 3'd1, 4'h3}, 1'b0, 1'b0, 1'b0);
        drive({1'b0, 3'd6, 1'b1, 4'b1000, 3'd4, 4'h8}, 1'b0, 1'b0, 1'b0);
        drive({1'b0, 3'd7, 1'b1, 4'b0000, 3'd7, 4'hC}, 1'b1, 1'b1, 1'b1);

        // Condition sweep (R4, R5, R10): every code against flag and input patterns.
        for (int p = 0; p < 4; p++) begin
            logic [3:0] pats [4];
            pats = '{4'h0, 4'h5, 4'hA, 4'hF};
            set_ext(pats[p]);
            for (int f = 0; f < 8; f++) begin
                for (int cc = 0; cc < 16; cc++) begin
                    drive({1'b0, 3'(cc), cc[0], 4'(cc), 3'(f), 4'(15 - cc)},
                          f[0], f[1], f[2]);
                end
            end
        end

        // Exact latency on one external input (R9): old value at first edge, new at second.
        set_ext(4'h0);
        @(negedge clk);
        instr = {1'b0, 3'd1, 1'b0, 4'b1101, 3'd3, 4'h4};
        fz = 1'b0; fc = 1'b0; fs = 1'b0;
        ext = 4'h2;
        e = model(instr, 1'b0, 1'b0, 1'b0, 4'h0); e.tag = "R9 first edge";
        sb_q.push_back(e);
        @(negedge clk);
        e = model(instr, 1'b0, 1'b0, 1'b0, 4'h2); e.tag = "R9 second edge";
        sb_q.push_back(e);
        ext_seen = 4'h2;

        @(negedge clk);
        while (sb_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is one failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule